// File: doc/BRIEF.md
# Bridge Cycle Claim and Retry Controller

This block serves one side of a two-port bus bridge. It watches the initiators on its side and acts when one of them starts a bus cycle by pulling the framing signal low. In that first clock it compares the address with two inclusive address windows. One window covers the devices on this side ("near"). The other covers the devices behind the bridge ("far"). The bridge claims only cycles aimed at the far side. It stays silent for local targets, for unmapped addresses, and for cycles that another device on this side has already claimed.

A claimed memory write is posted and answered with a normal completion at once. Any other claimed cycle is answered with a retry. Its address and command are then held in a single pending entry and replayed as a master cycle on the far side. If a target on that side claims the replay, the entry becomes ready and waits for the initiator to repeat the identical cycle, which then completes normally. If the replay gets no claim, the master side ends it with an abort (framing released first, ready released one clock later) and drops the entry. A ready entry that is never collected is dropped after a timeout.

Top module: `xbr_claim_ctrl`

## Requirements
- R1: A cycle start is the clock edge at which `t_frame_n` is low after being high at the previous edge. The response appears in the following cycle and lasts exactly one cycle. Holding `t_frame_n` low longer gives no further response.
- R2: An address with near_base <= address <= near_limit is never claimed, even if it also lies in the far window.
- R3: An address outside both windows is not claimed, including the address one above far_limit.
- R4: If `t_side_devsel_n` is low at the start edge, the cycle is not claimed.
- R5: A far-window cycle whose command is a memory write (4'b0111) or a memory write-and-invalidate (4'b1111) is claimed: `t_devsel_n` low and `t_done` high, both for one cycle. This includes addresses equal to far_base and far_limit.
- R6: When no entry is pending, a claimed far cycle with any other command gets `t_devsel_n` low with `t_retry` high. From that same cycle `m_frame_n` and `m_irdy_n` are low, with `m_addr`/`m_cmd` equal to the retried address and command.
- R7: If `m_devsel_n` is sampled low while the replay waits, the next cycle shows `m_frame_n` high with `m_irdy_n` still low, and the cycle after that shows both high with no abort.
- R8: If `m_devsel_n` stays high for 5 clocks after the replay starts, `m_frame_n` rises while `m_irdy_n` stays low for one cycle. Both are then high with `fwd_abort` high for one cycle, and the entry is dropped, so a later identical cycle is retried and replayed again.
- R9: When the entry is ready, a claimed cycle with address and command both equal to the stored pair gets `t_done`, and the entry is freed.
- R10: While an entry is held, any other claimed non-postable cycle gets `t_retry`, launches no replay, and leaves the entry intact.
- R11: A ready entry not collected within 2^TMO_LOG2 clocks (default 2^15) is dropped. A later repeat is retried and replayed anew.
- R12: After reset, `t_devsel_n`, `m_frame_n` and `m_irdy_n` are high, and `t_done`, `t_retry` and `fwd_abort` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| near_base | input | AW | Lowest address of this side |
| near_limit | input | AW | Highest address of this side |
| far_base | input | AW | Lowest address behind the bridge |
| far_limit | input | AW | Highest address behind the bridge |
| t_frame_n | input | 1 | Initiator framing, active low |
| t_addr | input | AW | Address at cycle start |
| t_cmd | input | 4 | Command at cycle start |
| t_side_devsel_n | input | 1 | Claim by another device on this side, active low |
| t_devsel_n | output | 1 | Bridge claim toward the initiator, active low |
| t_done | output | 1 | Claimed cycle ends normally |
| t_retry | output | 1 | Claimed cycle is retried |
| m_frame_n | output | 1 | Replay framing on the far side, active low |
| m_irdy_n | output | 1 | Replay master ready, active low |
| m_addr | output | AW | Replay address |
| m_cmd | output | 4 | Replay command |
| m_devsel_n | input | 1 | Far-side target claim, active low |
| fwd_abort | output | 1 | One-cycle pulse: replay ended by master abort |

## Verification
The decode is driven with addresses at both edges of the far window, one above its limit, inside the near window, and with a competing local claim. This separates an inclusive comparison from an off-by-one one and shows that local targets take priority. Postable and non-postable commands are issued to the same window to tell posting apart from retry. Read cycles are then repeated with the same address, with a different address, after a successful replay, after an aborted replay and after the timeout. These show whether the pending entry matches on the full address-and-command pair and whether it is freed at the right moment. The abort run counts the clocks with framing low, to separate a five-clock wait from a shorter or longer one.

// File: rtl/xbr_pkg.sv
// Shared types and command encodings for the bridge claim controller.
package xbr_pkg;
    typedef enum logic [1:0] {P_IDLE, P_FWD, P_READY} pend_st_t;
    typedef enum logic [1:0] {M_IDLE, M_WAIT, M_ENDF} mst_st_t;

    localparam logic [3:0] CMD_MEM_WRITE     = 4'b0111;
    localparam logic [3:0] CMD_MEM_WRITE_INV = 4'b1111;

    // Commands that may complete at once without a round trip.
    function automatic logic cmd_postable(input logic [3:0] cmd);
        return (cmd == CMD_MEM_WRITE) || (cmd == CMD_MEM_WRITE_INV);
    endfunction
endpackage

// File: rtl/xbr_win_decode.sv
// Inclusive address window compare.
// Assumes base <= limit; an inverted pair simply never hits.
module xbr_win_decode #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] limit,
    output logic          hit
);
    // Hit when the address lies between base and limit, both ends included.
    always_comb begin
        hit = (addr >= base) && (addr <= limit);
    end
endmodule

// File: rtl/xbr_fwd_master.sv
// Master-side sequencer for a replayed cycle.
// On launch it drives framing and ready low and waits for a target claim.
// After a claim or ABORT_CLKS unclaimed clocks it releases framing,
// then ready one clock later, and reports ok or abort with a pulse.
// Assumes launch is never raised while a replay is in flight.
module xbr_fwd_master #(
    parameter int ABORT_CLKS = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic devsel_n,
    output logic frame_n,
    output logic irdy_n,
    output logic done_ok,
    output logic done_abort
);
    import xbr_pkg::*;

    localparam int CW = (ABORT_CLKS > 1) ? $clog2(ABORT_CLKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(ABORT_CLKS - 1);

    mst_st_t       st;
    logic [CW-1:0] wait_cnt;
    logic          claimed;

    // State, wait counter and outcome pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= M_IDLE;
            wait_cnt   <= '0;
            claimed    <= 1'b0;
            done_ok    <= 1'b0;
            done_abort <= 1'b0;
        end else begin
            done_ok    <= 1'b0;
            done_abort <= 1'b0;
            case (st)
                M_IDLE: begin
                    if (launch) begin
                        st       <= M_WAIT;
                        wait_cnt <= '0;
                    end
                end
                M_WAIT: begin
                    if (!devsel_n) begin
                        st      <= M_ENDF;
                        claimed <= 1'b1;
                    end else if (wait_cnt == LAST) begin
                        st      <= M_ENDF;
                        claimed <= 1'b0;
                    end else begin
                        wait_cnt <= wait_cnt + 1'b1;
                    end
                end
                M_ENDF: begin
                    st         <= M_IDLE;
                    done_ok    <= claimed;
                    done_abort <= !claimed;
                end
                default: st <= M_IDLE;
            endcase
        end
    end

    // Bus pins follow the state: framing only in wait, ready also in the end phase.
    always_comb begin
        frame_n = (st != M_WAIT);
        irdy_n  = (st == M_IDLE);
    end
endmodule

// File: rtl/xbr_pend_track.sv
// Pending-transaction tracker and target response.
// Decides done or retry for a claimed cycle, holds one entry for the
// replay, matches the initiator's repeat and drops a stale entry.
// Assumes claim is a single-cycle qualifier at the cycle start edge.
module xbr_pend_track #(
    parameter int AW       = 32,
    parameter int TMO_LOG2 = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          claim,
    input  logic [AW-1:0] addr,
    input  logic [3:0]    cmd,
    input  logic          fwd_ok,
    input  logic          fwd_abort,
    output logic          launch,
    output logic          devsel_n,
    output logic          done,
    output logic          retry,
    output logic [AW-1:0] ent_addr,
    output logic [3:0]    ent_cmd
);
    import xbr_pkg::*;

    pend_st_t            st;
    logic [TMO_LOG2-1:0] age;
    logic                match;
    logic                dec_done;
    logic                dec_retry;

    // Response decision for the current start edge.
    always_comb begin
        match     = (st == P_READY) && (addr == ent_addr) && (cmd == ent_cmd);
        dec_done  = claim && (cmd_postable(cmd) || match);
        dec_retry = claim && !dec_done;
        launch    = dec_retry && (st == P_IDLE);
    end

    // One-cycle target response registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            devsel_n <= 1'b1;
            done     <= 1'b0;
            retry    <= 1'b0;
        end else begin
            devsel_n <= !claim;
            done     <= dec_done;
            retry    <= dec_retry;
        end
    end

    // Entry life cycle: capture, replay, ready, collect or expire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= P_IDLE;
            age      <= '0;
            ent_addr <= '0;
            ent_cmd  <= '0;
        end else begin
            case (st)
                P_IDLE: begin
                    if (launch) begin
                        st       <= P_FWD;
                        ent_addr <= addr;
                        ent_cmd  <= cmd;
                    end
                end
                P_FWD: begin
                    if (fwd_ok) begin
                        st  <= P_READY;
                        age <= '0;
                    end else if (fwd_abort) begin
                        st <= P_IDLE;
                    end
                end
                P_READY: begin
                    if (claim && match) begin
                        st <= P_IDLE;
                    end else if (&age) begin
                        st <= P_IDLE;
                    end else begin
                        age <= age + 1'b1;
                    end
                end
                default: st <= P_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/xbr_claim_ctrl.sv
// Bridge cycle claim and retry controller, one bridge side.
// Detects a cycle start, decodes it against the near and far windows,
// and hands claimed cycles to the pending tracker and replay master.
// Assumes window registers are stable while cycles run.
module xbr_claim_ctrl #(
    parameter int AW         = 32,
    parameter int ABORT_CLKS = 5,
    parameter int TMO_LOG2   = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] near_base,
    input  logic [AW-1:0] near_limit,
    input  logic [AW-1:0] far_base,
    input  logic [AW-1:0] far_limit,
    input  logic          t_frame_n,
    input  logic [AW-1:0] t_addr,
    input  logic [3:0]    t_cmd,
    input  logic          t_side_devsel_n,
    output logic          t_devsel_n,
    output logic          t_done,
    output logic          t_retry,
    output logic          m_frame_n,
    output logic          m_irdy_n,
    output logic [AW-1:0] m_addr,
    output logic [3:0]    m_cmd,
    input  logic          m_devsel_n,
    output logic          fwd_abort
);
    localparam int NWIN = 2;  // index 0: near side, index 1: far side

    logic [AW-1:0] win_base  [NWIN];
    logic [AW-1:0] win_limit [NWIN];
    logic [NWIN-1:0] hit;
    logic frame_q;
    logic start;
    logic claim;
    logic launch;
    logic fwd_ok;

    // Gather the window bounds into indexable arrays.
    always_comb begin
        win_base[0]  = near_base;
        win_limit[0] = near_limit;
        win_base[1]  = far_base;
        win_limit[1] = far_limit;
    end

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        xbr_win_decode #(.AW(AW)) u_dec (
            .addr  (t_addr),
            .base  (win_base[g]),
            .limit (win_limit[g]),
            .hit   (hit[g])
        );
    end

    // Previous framing level for start-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) frame_q <= 1'b1;
        else        frame_q <= t_frame_n;
    end

    // Claim only far targets not hit locally and not claimed by a local device.
    always_comb begin
        start = frame_q && !t_frame_n;
        claim = start && hit[1] && !hit[0] && t_side_devsel_n;
    end

    xbr_pend_track #(.AW(AW), .TMO_LOG2(TMO_LOG2)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .claim     (claim),
        .addr      (t_addr),
        .cmd       (t_cmd),
        .fwd_ok    (fwd_ok),
        .fwd_abort (fwd_abort),
        .launch    (launch),
        .devsel_n  (t_devsel_n),
        .done      (t_done),
        .retry     (t_retry),
        .ent_addr  (m_addr),
        .ent_cmd   (m_cmd)
    );

    xbr_fwd_master #(.ABORT_CLKS(ABORT_CLKS)) u_mst (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .devsel_n   (m_devsel_n),
        .frame_n    (m_frame_n),
        .irdy_n     (m_irdy_n),
        .done_ok    (fwd_ok),
        .done_abort (fwd_abort)
    );
endmodule

// File: rtl/xbr_claim_ctrl_chk.sv
// Property checker for the claim controller, attached by bind.
// Observes ports only; the abort window is tracked with a local counter.
module xbr_claim_ctrl_chk #(
    parameter int AW         = 32,
    parameter int ABORT_CLKS = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] near_base,
    input logic [AW-1:0] near_limit,
    input logic [AW-1:0] far_base,
    input logic [AW-1:0] far_limit,
    input logic          t_frame_n,
    input logic [AW-1:0] t_addr,
    input logic [3:0]    t_cmd,
    input logic          t_side_devsel_n,
    input logic          t_devsel_n,
    input logic          t_done,
    input logic          t_retry,
    input logic          m_frame_n,
    input logic          m_irdy_n,
    input logic          fwd_abort
);
    localparam int RW = $clog2(ABORT_CLKS + 2);

    logic          near_in;
    logic          far_in;
    logic          post_cmd;
    logic [RW-1:0] low_run;

    // Window and command views computed from the ports.
    always_comb begin
        near_in  = (t_addr >= near_base) && (t_addr <= near_limit);
        far_in   = (t_addr >= far_base) && (t_addr <= far_limit);
        post_cmd = (t_cmd == 4'b0111) || (t_cmd == 4'b1111);
    end

    // Length of the current run of low replay framing.
    always_ff @(posedge clk) begin
        if (!rst_n)          low_run <= '0;
        else if (!m_frame_n) low_run <= low_run + 1'b1;
        else                 low_run <= '0;
    end

    // R1: a claim lasts one cycle and follows a low framing sample.
    a_r1_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !t_devsel_n |=> t_devsel_n);
    a_r1_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !t_devsel_n |-> $past(!t_frame_n));
    // R2: local targets are never claimed.
    a_r2_local_silent: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(t_frame_n) && near_in) |=> t_devsel_n);
    // R5: postable far writes complete at once.
    a_r5_post_done: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(t_frame_n) && far_in && !near_in && t_side_devsel_n && post_cmd) |=> (t_done && !t_devsel_n));
    // R6: done and retry never together, and only with a claim.
    a_r6_resp_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({t_done, t_retry}));
    a_r6_resp_claimed: assert property (@(posedge clk) disable iff (!rst_n)
        (t_done || t_retry) |-> !t_devsel_n);
    // R7: framing is released while ready is still held.
    a_r7_frame_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m_frame_n) |-> !m_irdy_n);
    // R8: ready is released only after framing, framing never low past the window.
    a_r8_irdy_second: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m_irdy_n) |-> $past(m_frame_n));
    a_r8_window: assert property (@(posedge clk) disable iff (!rst_n)
        low_run <= RW'(ABORT_CLKS));
    a_r8_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_abort |-> (m_frame_n && m_irdy_n));
endmodule

bind xbr_claim_ctrl xbr_claim_ctrl_chk #(.AW(AW), .ABORT_CLKS(ABORT_CLKS)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .near_base       (near_base),
    .near_limit      (near_limit),
    .far_base        (far_base),
    .far_limit       (far_limit),
    .t_frame_n       (t_frame_n),
    .t_addr          (t_addr),
    .t_cmd           (t_cmd),
    .t_side_devsel_n (t_side_devsel_n),
    .t_devsel_n      (t_devsel_n),
    .t_done          (t_done),
    .t_retry         (t_retry),
    .m_frame_n       (m_frame_n),
    .m_irdy_n        (m_irdy_n),
    .fwd_abort       (fwd_abort)
);

// File: tb/xbr_claim_ctrl_test.sv
// Directed bench for the claim controller: one task per scenario.
module xbr_claim_ctrl_test;
    localparam int AW = 32;
    localparam logic [3:0] C_WR   = 4'b0111;
    localparam logic [3:0] C_WRI  = 4'b1111;
    localparam logic [3:0] C_RD   = 4'b0110;
    localparam logic [31:0] NB = 32'h0000_0000, NL = 32'h0FFF_FFFF;
    localparam logic [31:0] FB = 32'h1000_0000, FL = 32'h1FFF_FFFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic t_frame_n = 1'b1;
    logic [AW-1:0] t_addr = '0;
    logic [3:0] t_cmd = '0;
    logic t_side_devsel_n = 1'b1;
    logic m_devsel_n = 1'b1;
    logic t_devsel_n, t_done, t_retry, m_frame_n, m_irdy_n, fwd_abort;
    logic [AW-1:0] m_addr;
    logic [3:0] m_cmd;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    xbr_claim_ctrl #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n),
        .near_base(NB), .near_limit(NL), .far_base(FB), .far_limit(FL),
        .t_frame_n(t_frame_n), .t_addr(t_addr), .t_cmd(t_cmd),
        .t_side_devsel_n(t_side_devsel_n),
        .t_devsel_n(t_devsel_n), .t_done(t_done), .t_retry(t_retry),
        .m_frame_n(m_frame_n), .m_irdy_n(m_irdy_n), .m_addr(m_addr), .m_cmd(m_cmd),
        .m_devsel_n(m_devsel_n), .fwd_abort(fwd_abort)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Start one cycle, sample the response one clock later, release framing.
    task automatic issue(input logic [31:0] a, input logic [3:0] c, input logic sd,
                         output logic dv, output logic dn, output logic rt, output logic mf);
        @(negedge clk);
        t_addr = a; t_cmd = c; t_side_devsel_n = sd; t_frame_n = 1'b0;
        @(negedge clk);
        dv = t_devsel_n; dn = t_done; rt = t_retry; mf = m_frame_n;
        t_frame_n = 1'b1; t_side_devsel_n = 1'b1;
    endtask

    // Claim the replay on the far side; called right after the retry sample.
    task automatic claim_replay();
        m_devsel_n = 1'b0;
        @(negedge clk);
        check("R7 frame released", {62'd0, m_frame_n, m_irdy_n}, 64'b10);
        m_devsel_n = 1'b1;
        @(negedge clk);
        check("R7 both released no abort", {61'd0, m_frame_n, m_irdy_n, fwd_abort}, 64'b110);
        repeat (2) @(negedge clk);
    endtask

    task automatic test_reset();
        check("R12 reset target", {61'd0, t_devsel_n, t_done, t_retry}, 64'b100);
        check("R12 reset master", {61'd0, m_frame_n, m_irdy_n, fwd_abort}, 64'b110);
    endtask

    task automatic test_start_once();
        @(negedge clk);
        t_addr = FB + 32'h40; t_cmd = C_WR; t_frame_n = 1'b0;
        @(negedge clk);
        check("R1 first response", {62'd0, t_devsel_n, t_done}, 64'b01);
        @(negedge clk);
        check("R1 held framing no repeat", {62'd0, t_devsel_n, t_done}, 64'b10);
        @(negedge clk);
        check("R1 still silent", {63'd0, t_devsel_n}, 64'd1);
        t_frame_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic test_posted();
        logic dv, dn, rt, mf;
        issue(FB, C_WR, 1'b1, dv, dn, rt, mf);
        check("R5 write at far_base", {60'd0, dv, dn, rt, mf}, 64'b0101);
        issue(FL, C_WRI, 1'b1, dv, dn, rt, mf);
        check("R5 invalidate at far_limit", {60'd0, dv, dn, rt, mf}, 64'b0101);
    endtask

    task automatic test_no_claim();
        logic dv, dn, rt, mf;
        issue(NL, C_RD, 1'b1, dv, dn, rt, mf);
        check("R2 near target silent", {61'd0, dv, dn, rt}, 64'b100);
        issue(FL + 32'd1, C_WR, 1'b1, dv, dn, rt, mf);
        check("R3 above far_limit silent", {61'd0, dv, dn, rt}, 64'b100);
        issue(FB + 32'h100, C_WR, 1'b0, dv, dn, rt, mf);
        check("R4 local claim wins", {61'd0, dv, dn, rt}, 64'b100);
    endtask

    task automatic test_retry_match();
        logic dv, dn, rt, mf;
        issue(FB + 32'h80, C_RD, 1'b1, dv, dn, rt, mf);
        check("R6 retry and launch", {60'd0, dv, dn, rt, mf}, 64'b0010);
        check("R6 replay address", {32'd0, m_addr}, {32'd0, FB + 32'h80});
        check("R6 replay command", {60'd0, m_cmd}, {60'd0, C_RD});
        check("R6 ready low with frame", {63'd0, m_irdy_n}, 64'd0);
        claim_replay();
        issue(FB + 32'hC0, C_RD, 1'b1, dv, dn, rt, mf);
        check("R10 other cycle retried no launch", {60'd0, dv, dn, rt, mf}, 64'b0011);
        issue(FB + 32'h80, 4'b1100, 1'b1, dv, dn, rt, mf);
        check("R10 command mismatch retried", {61'd0, dv, dn, rt}, 64'b001);
        issue(FB + 32'h80, C_RD, 1'b1, dv, dn, rt, mf);
        check("R9 repeat completes", {60'd0, dv, dn, rt, mf}, 64'b0101);
    endtask

    task automatic test_abort();
        logic dv, dn, rt, mf;
        issue(FB + 32'h200, C_RD, 1'b1, dv, dn, rt, mf);
        check("R8 retry and launch", {60'd0, dv, dn, rt, mf}, 64'b0010);
        for (int i = 1; i < 5; i++) begin
            @(negedge clk);
            check("R8 frame held in window", {62'd0, m_frame_n, m_irdy_n}, 64'b00);
        end
        @(negedge clk);
        check("R8 frame released first", {61'd0, m_frame_n, m_irdy_n, fwd_abort}, 64'b100);
        @(negedge clk);
        check("R8 ready released with abort", {61'd0, m_frame_n, m_irdy_n, fwd_abort}, 64'b111);
        repeat (2) @(negedge clk);
        issue(FB + 32'h200, C_RD, 1'b1, dv, dn, rt, mf);
        check("R8 entry dropped, replay again", {60'd0, dv, dn, rt, mf}, 64'b0010);
        claim_replay();
    endtask

    task automatic test_timeout();
        logic dv, dn, rt, mf;
        repeat ((1 << 15) + 20) @(negedge clk);
        issue(FB + 32'h200, C_RD, 1'b1, dv, dn, rt, mf);
        check("R11 stale entry dropped", {60'd0, dv, dn, rt, mf}, 64'b0010);
        claim_replay();
        issue(FB + 32'h200, C_RD, 1'b1, dv, dn, rt, mf);
        check("R11 fresh entry collected", {61'd0, dv, dn, rt}, 64'b010);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_start_once();
        test_posted();
        test_no_claim();
        test_retry_match();
        test_abort();
        test_timeout();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule